// File: doc/BRIEF.md
# Bit-Band Alias Bus Translator

This block sits between a single bus master and a 32-bit word-addressed memory or peripheral bus. Two alias windows are mapped onto two primary regions: each word in an alias window stands for one bit of one word in the matching primary region. The block decodes every master request. Requests outside both alias windows go straight through to the downstream bus. Requests inside a window become single-bit operations on the underlying word.

An alias read performs one downstream read and returns the selected bit in bit 0 of the read data. An alias write performs a locked read-modify-write. The master issues one store. The block reads the word, changes only the selected bit to bit 0 of the store data, and writes the word back. The downstream lock stays asserted for both halves, so no other transfer can get between the read and the write. Alias accesses whose address is not word aligned complete with an error and never reach the downstream bus.

The master holds a request until the block pulses `m_ready`. The downstream side uses the same hold-until-acknowledge rule with `s_req` and `s_ack`.

Top module: `bitband_xlate`

## Requirements
- R1: After reset, `m_ready`, `m_err`, `s_req` and `s_lock` are all low.
- R2: A request whose address lies in neither alias window produces exactly one downstream transfer. That transfer carries the unchanged address, direction and write data, with `s_lock` low. On a read, the downstream read data is returned on `m_rdata`.
- R3: The memory alias window spans 0x2200_0000 to 0x23FF_FFFF and maps onto the region at 0x2000_0000. The peripheral alias window spans 0x4200_0000 to 0x43FF_FFFF and maps onto the region at 0x4000_0000. With `off` = alias address minus window base, the target word is region base + 4·`off[24:7]` and the target bit is `off[6:2]`. For example, 0x2200_0008 selects bit 2 of 0x2000_0000, and 0x2200_0080 selects bit 0 of 0x2000_0004.
- R4: An aligned alias read produces exactly one unlocked downstream read of the target word. It returns the target bit in `m_rdata[0]`, with bits 31:1 zero.
- R5: An aligned alias write sets the target bit of the target word to `m_wdata[0]`. Every other bit of the word keeps its value, and bits 31:1 of `m_wdata` have no effect.
- R6: An alias write makes exactly two downstream transfers, a read followed by a write of the same word, and both carry `s_lock` high. `s_lock` is only ever high while `s_req` is high. `s_req` and `s_addr` are held steady until `s_ack`.
- R7: An alias request with address bits [1:0] not equal to 00 completes with `m_err` high in the `m_ready` cycle. It makes no downstream transfer and leaves memory unchanged.
- R8: `m_ready` is a one-cycle pulse, given once per accepted request, and stays low while the operation is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 1 | Master request, held until `m_ready` |
| m_we | input | 1 | Master write enable |
| m_addr | input | 32 | Master byte address |
| m_wdata | input | 32 | Master write data |
| m_ready | output | 1 | One-cycle completion pulse; low means the master is stalled |
| m_rdata | output | 32 | Read data, valid with `m_ready` |
| m_err | output | 1 | Error response, valid with `m_ready` |
| s_req | output | 1 | Downstream request, held until `s_ack` |
| s_we | output | 1 | Downstream write enable |
| s_addr | output | 32 | Downstream word address |
| s_wdata | output | 32 | Downstream write data |
| s_lock | output | 1 | Downstream lock across a read-modify-write |
| s_ack | input | 1 | Downstream transfer complete |
| s_rdata | input | 32 | Downstream read data, valid with `s_ack` |

## Verification
Alias reads are tried on a bit that is set and on a bit that is clear in the same word. This shows that the bit is actually selected and not copied from a fixed position. Alias writes use store data whose upper bits are the inverse of bit 0. This separates a correct single-bit update from a whole-word store, and also catches a merge that takes the wrong data bit. Bit 31 of a word, the first bit of the next word and the peripheral window are each addressed, which exposes errors in the byte-offset and bit-index arithmetic. The bench counts downstream transfers and locked transfers for each request. These counts tell a pass-through request, a plain alias read, a locked read-modify-write and a rejected misaligned request apart.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS,
    ST_RMW_RD,
    ST_RMW_WR,
    ST_DONE
  } bb_state_t;
endpackage

// File: rtl/bb_decode.sv
module bb_decode #(
  parameter int unsigned          ADDR_W       = 32,
  parameter int unsigned          DATA_W       = 32,
  parameter logic [ADDR_W-1:0]    MEM_BASE     = 32'h2000_0000,
  parameter logic [ADDR_W-1:0]    PER_BASE     = 32'h4000_0000,
  parameter logic [ADDR_W-1:0]    ALIAS_OFS    = 32'h0200_0000,
  parameter int unsigned          REGION_BYTES = 1024 * 1024
) (
  input  logic [ADDR_W-1:0]         addr,
  output logic                      hit,
  output logic                      misalign,
  output logic [ADDR_W-1:0]         word_addr,
  output logic [$clog2(DATA_W)-1:0] bit_idx
);
  localparam int unsigned IDX_W  = $clog2(DATA_W);
  localparam int unsigned LANE_W = $clog2(DATA_W / 8);
  localparam logic [ADDR_W-1:0] WIN_SIZE = ADDR_W'(REGION_BYTES * DATA_W);
  localparam logic [ADDR_W-1:0] AMEM = MEM_BASE + ALIAS_OFS;
  localparam logic [ADDR_W-1:0] APER = PER_BASE + ALIAS_OFS;

  logic [ADDR_W-1:0] off_mem, off_per, off;
  logic              in_mem, in_per;

  always_comb begin
    off_mem  = addr - AMEM;
    off_per  = addr - APER;
    in_mem   = off_mem < WIN_SIZE;
    in_per   = off_per < WIN_SIZE;
    hit      = in_mem | in_per;
    off      = in_mem ? off_mem : off_per;
    misalign = hit && (addr[LANE_W-1:0] != '0);
    bit_idx  = off[IDX_W+LANE_W-1:LANE_W];
    word_addr = (in_mem ? MEM_BASE : PER_BASE)
              + ((off >> (IDX_W + LANE_W)) << LANE_W);
  end
endmodule

// File: rtl/bb_bitops.sv
module bb_bitops #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]         word,
  input  logic [$clog2(DATA_W)-1:0] idx,
  input  logic                      new_bit,
  output logic [DATA_W-1:0]         extracted,
  output logic [DATA_W-1:0]         merged
);
  always_comb begin
    extracted    = '0;
    extracted[0] = word[idx];
    merged       = word;
    merged[idx]  = new_bit;
  end
endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl
  import bb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      m_req,
  input  logic                      m_we,
  input  logic [ADDR_W-1:0]         m_addr,
  input  logic [DATA_W-1:0]         m_wdata,
  output logic                      m_ready,
  output logic [DATA_W-1:0]         m_rdata,
  output logic                      m_err,
  input  logic                      dec_hit,
  input  logic                      dec_misalign,
  input  logic [ADDR_W-1:0]         dec_word,
  input  logic [$clog2(DATA_W)-1:0] dec_idx,
  output logic [$clog2(DATA_W)-1:0] idx_q,
  output logic                      bit_q,
  input  logic [DATA_W-1:0]         bit_extract,
  input  logic [DATA_W-1:0]         bit_merge,
  output logic                      s_req,
  output logic                      s_we,
  output logic [ADDR_W-1:0]         s_addr,
  output logic [DATA_W-1:0]         s_wdata,
  output logic                      s_lock,
  input  logic                      s_ack,
  input  logic [DATA_W-1:0]         s_rdata
);
  bb_state_t state;
  logic      alias_wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      m_ready    <= 1'b0;
      m_err      <= 1'b0;
      m_rdata    <= '0;
      s_req      <= 1'b0;
      s_we       <= 1'b0;
      s_addr     <= '0;
      s_wdata    <= '0;
      s_lock     <= 1'b0;
      idx_q      <= '0;
      bit_q      <= 1'b0;
      alias_wr_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (m_req) begin
            if (dec_misalign) begin
              m_ready <= 1'b1;
              m_err   <= 1'b1;
              m_rdata <= '0;
              state   <= ST_DONE;
            end else if (dec_hit) begin
              s_req      <= 1'b1;
              s_we       <= 1'b0;
              s_addr     <= dec_word;
              s_lock     <= m_we;
              idx_q      <= dec_idx;
              bit_q      <= m_wdata[0];
              alias_wr_q <= m_we;
              state      <= ST_RMW_RD;
            end else begin
              s_req   <= 1'b1;
              s_we    <= m_we;
              s_addr  <= m_addr;
              s_wdata <= m_wdata;
              state   <= ST_PASS;
            end
          end
        end
        ST_PASS: begin
          if (s_ack) begin
            s_req   <= 1'b0;
            s_we    <= 1'b0;
            m_rdata <= s_rdata;
            m_ready <= 1'b1;
            state   <= ST_DONE;
          end
        end
        ST_RMW_RD: begin
          if (s_ack) begin
            if (alias_wr_q) begin
              s_we    <= 1'b1;
              s_wdata <= bit_merge;
              state   <= ST_RMW_WR;
            end else begin
              s_req   <= 1'b0;
              m_rdata <= bit_extract;
              m_ready <= 1'b1;
              state   <= ST_DONE;
            end
          end
        end
        ST_RMW_WR: begin
          if (s_ack) begin
            s_req   <= 1'b0;
            s_we    <= 1'b0;
            s_lock  <= 1'b0;
            m_rdata <= '0;
            m_ready <= 1'b1;
            state   <= ST_DONE;
          end
        end
        default: begin
          m_ready <= 1'b0;
          m_err   <= 1'b0;
          state   <= ST_IDLE;
        end
      endcase
    end
  end

  // R6
  lock_within_req_chk: assert property (@(posedge clk) disable iff (rst)
    s_lock |-> s_req);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (s_req && !s_ack) |=> (s_req && $stable(s_addr)));

  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    m_ready |=> !m_ready);

  // R7
  err_no_bus_chk: assert property (@(posedge clk) disable iff (rst)
    m_err |-> (m_ready && !s_req));

  // R8
  ready_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    m_ready |-> !s_req);
endmodule

// File: rtl/bitband_xlate.sv
module bitband_xlate #(
  parameter int unsigned       ADDR_W       = 32,
  parameter int unsigned       DATA_W       = 32,
  parameter logic [ADDR_W-1:0] MEM_BASE     = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] PER_BASE     = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] ALIAS_OFS    = 32'h0200_0000,
  parameter int unsigned       REGION_BYTES = 1024 * 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              m_req,
  input  logic              m_we,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [DATA_W-1:0] m_wdata,
  output logic              m_ready,
  output logic [DATA_W-1:0] m_rdata,
  output logic              m_err,
  output logic              s_req,
  output logic              s_we,
  output logic [ADDR_W-1:0] s_addr,
  output logic [DATA_W-1:0] s_wdata,
  output logic              s_lock,
  input  logic              s_ack,
  input  logic [DATA_W-1:0] s_rdata
);
  localparam int unsigned IDX_W = $clog2(DATA_W);

  logic              dec_hit, dec_misalign;
  logic [ADDR_W-1:0] dec_word;
  logic [IDX_W-1:0]  dec_idx, idx_q;
  logic              bit_q;
  logic [DATA_W-1:0] bit_extract, bit_merge;

  bb_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_BASE(MEM_BASE),
    .PER_BASE(PER_BASE), .ALIAS_OFS(ALIAS_OFS), .REGION_BYTES(REGION_BYTES)
  ) u_decode (
    .addr(m_addr), .hit(dec_hit), .misalign(dec_misalign),
    .word_addr(dec_word), .bit_idx(dec_idx)
  );

  bb_bitops #(.DATA_W(DATA_W)) u_bitops (
    .word(s_rdata), .idx(idx_q), .new_bit(bit_q),
    .extracted(bit_extract), .merged(bit_merge)
  );

  bb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_ready(m_ready), .m_rdata(m_rdata), .m_err(m_err),
    .dec_hit(dec_hit), .dec_misalign(dec_misalign),
    .dec_word(dec_word), .dec_idx(dec_idx),
    .idx_q(idx_q), .bit_q(bit_q),
    .bit_extract(bit_extract), .bit_merge(bit_merge),
    .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_lock(s_lock), .s_ack(s_ack), .s_rdata(s_rdata)
  );
endmodule

// File: tb/bitband_xlate_tb.sv
module bitband_xlate_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        m_req = 1'b0, m_we = 1'b0;
  logic [31:0] m_addr = '0, m_wdata = '0;
  logic        m_ready, m_err;
  logic [31:0] m_rdata;
  logic        s_req, s_we, s_lock;
  logic [31:0] s_addr, s_wdata;
  logic        s_ack;
  logic [31:0] s_rdata;

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] mem [128];
  int xfer_cnt = 0, lock_cnt = 0, ready_cnt = 0;
  logic [31:0] last_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitband_xlate u_dut (
    .clk(clk), .rst(rst), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata), .m_err(m_err),
    .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_lock(s_lock), .s_ack(s_ack), .s_rdata(s_rdata)
  );

  function automatic int midx(input logic [31:0] a);
    return {25'd0, a[30], a[7:2]};
  endfunction

  // Downstream model: one-cycle acknowledge, one transfer per acknowledge.
  always @(posedge clk) begin
    if (rst) begin
      s_ack <= 1'b0;
      s_rdata <= '0;
    end else if (s_req && !s_ack) begin
      s_ack <= 1'b1;
      s_rdata <= mem[midx(s_addr)];
      if (s_we) mem[midx(s_addr)] <= s_wdata;
      xfer_cnt <= xfer_cnt + 1;
      last_addr <= s_addr;
      if (s_lock) lock_cnt <= lock_cnt + 1;
    end else begin
      s_ack <= 1'b0;
    end
    if (!rst && m_ready) ready_cnt <= ready_cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [31:0] a, input logic [31:0] wd,
                      output logic [31:0] rd, output logic err);
    int guard;
    @(negedge clk);
    m_req = 1'b1; m_we = we; m_addr = a; m_wdata = wd;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!m_ready && guard < 50);
    rd = m_rdata; err = m_err;
    m_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 m_ready", {31'd0, m_ready}, 32'd0);
    check("R1 m_err",   {31'd0, m_err},   32'd0);
    check("R1 s_req",   {31'd0, s_req},   32'd0);
    check("R1 s_lock",  {31'd0, s_lock},  32'd0);
  endtask

  task automatic t_pass;
    logic [31:0] rd; logic e; int x0, l0, r0;
    x0 = xfer_cnt; l0 = lock_cnt; r0 = ready_cnt;
    xfer(1'b1, 32'h2000_0010, 32'hCAFE_0123, rd, e);
    check("R2 pass write data", mem[midx(32'h2000_0010)], 32'hCAFE_0123);
    check("R2 pass addr", last_addr, 32'h2000_0010);
    mem[midx(32'h2400_0020)] = 32'h1234_5678;
    xfer(1'b0, 32'h2400_0020, 32'h0, rd, e);
    check("R2 pass read data", rd, 32'h1234_5678);
    check("R2 pass transfers", xfer_cnt - x0, 2);
    check("R2 pass unlocked", lock_cnt - l0, 0);
    check("R8 one ready per request", ready_cnt - r0, 2);
  endtask

  task automatic t_alias_read;
    logic [31:0] rd; logic e; int x0, l0;
    mem[midx(32'h2000_0000)] = 32'hFFFF_FFF4;
    x0 = xfer_cnt; l0 = lock_cnt;
    xfer(1'b0, 32'h2200_0008, 32'h0, rd, e);
    check("R4 read set bit 2", rd, 32'd1);
    check("R3 read word addr", last_addr, 32'h2000_0000);
    xfer(1'b0, 32'h2200_000C, 32'h0, rd, e);
    check("R4 read clear bit 3", rd, 32'd0);
    check("R4 single unlocked read", xfer_cnt - x0, 2);
    check("R4 no lock on read", lock_cnt - l0, 0);
  endtask

  task automatic t_alias_write;
    logic [31:0] rd; logic e; int x0, l0;
    mem[midx(32'h2000_0000)] = 32'hA5A5_0F0F;
    x0 = xfer_cnt; l0 = lock_cnt;
    xfer(1'b1, 32'h2200_0004, 32'h0000_0000, rd, e);
    check("R5 clear bit 1", mem[midx(32'h2000_0000)], 32'hA5A5_0F0D);
    check("R6 rmw transfers", xfer_cnt - x0, 2);
    check("R6 rmw locked", lock_cnt - l0, 2);
    xfer(1'b1, 32'h2200_0010, 32'hFFFF_FFFF, rd, e);
    check("R5 set bit 4", mem[midx(32'h2000_0000)], 32'hA5A5_0F1D);
    xfer(1'b1, 32'h2200_0000, 32'hFFFF_FFFE, rd, e);
    check("R5 upper wdata ignored", mem[midx(32'h2000_0000)], 32'hA5A5_0F1C);
  endtask

  task automatic t_bit_positions;
    logic [31:0] rd; logic e;
    mem[midx(32'h2000_0000)] = 32'h0;
    mem[midx(32'h2000_0004)] = 32'h0;
    xfer(1'b1, 32'h2200_007C, 32'h1, rd, e);
    check("R3 bit 31", mem[midx(32'h2000_0000)], 32'h8000_0000);
    xfer(1'b1, 32'h2200_0080, 32'h1, rd, e);
    check("R3 next word bit 0", mem[midx(32'h2000_0004)], 32'h0000_0001);
    check("R3 next word addr", last_addr, 32'h2000_0004);
    mem[midx(32'h4000_0000)] = 32'h0;
    xfer(1'b1, 32'h4200_0004, 32'h1, rd, e);
    check("R3 peripheral bit 1", mem[midx(32'h4000_0000)], 32'h0000_0002);
    xfer(1'b0, 32'h4200_0000, 32'h0, rd, e);
    check("R3 peripheral bit 0 read", rd, 32'd0);
    check("R3 peripheral addr", last_addr, 32'h4000_0000);
  endtask

  task automatic t_misalign;
    logic [31:0] rd; logic e; int x0;
    mem[midx(32'h2000_0000)] = 32'h0000_0000;
    x0 = xfer_cnt;
    xfer(1'b1, 32'h2200_0009, 32'h1, rd, e);
    check("R7 error flag", {31'd0, e}, 32'd1);
    check("R7 no downstream", xfer_cnt - x0, 0);
    check("R7 memory unchanged", mem[midx(32'h2000_0000)], 32'h0);
    xfer(1'b0, 32'h4200_0002, 32'h0, rd, e);
    check("R7 read error", {31'd0, e}, 32'd1);
    xfer(1'b0, 32'h2200_0008, 32'h0, rd, e);
    check("R7 aligned no error", {31'd0, e}, 32'd0);
  endtask

  task automatic t_stall;
    int x0;
    @(negedge clk);
    m_req = 1'b1; m_we = 1'b1; m_addr = 32'h2200_0000; m_wdata = 32'h1;
    x0 = 0;
    repeat (3) begin
      @(negedge clk);
      if (m_ready) x0++;
    end
    check("R8 stalled during rmw", x0, 0);
    while (!m_ready) @(negedge clk);
    m_req = 1'b0;
    @(negedge clk);
    check("R8 ready drops", {31'd0, m_ready}, 32'd0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pass();
    t_alias_read();
    t_alias_write();
    t_bit_positions();
    t_misalign();
    t_stall();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule